// File: doc/BRIEF.md
# Ramp-Dithered Single-Bit Decimating Averager

This block turns a byte-wide stream of comparator decisions into multi-bit samples. Each input bit comes from a logic-level comparator. The bit reads 1 when the analog signal on that channel is above a shared dither voltage. The block produces that dither as a digital ramp code for an external DAC. The code steps by one on every accepted sample, so it sweeps its whole range exactly once per averaging window.

Each of the eight channels has its own counter. The counter adds up the ones that arrive during a window of 256 accepted samples. When the window closes, the block registers one 8-bit value per channel and raises a strobe for a single clock. The output rate is therefore 1/256 of the sample rate.

A small sequencer state machine tracks the window position and drives the strobe. It has three states:
- `SEQ_PRIME`: the first window after reset, before any result exists.
- `SEQ_ACCUM`: a later window, with the previous results held at the output.
- `SEQ_EMIT`: the one clock in which new results are announced.

It has three transitions:
- *close_first* (`SEQ_PRIME` to `SEQ_EMIT`): the last sample of the first window is accepted.
- *close_next* (`SEQ_ACCUM` to `SEQ_EMIT`): the last sample of any later window is accepted.
- *resume* (`SEQ_EMIT` to `SEQ_ACCUM`): always taken on the clock after `SEQ_EMIT`.

Top module: `ramp_dither_avg`

## Requirements
- R1: After reset `dither_code` is 0, `avg_valid` is 0 and `avg_out` is all zeros.
- R2: `dither_code` increases by one, modulo 256, on each clock edge where `sample_en` is 1. It holds its value on every other edge. Its value in a cycle is the index (0..255) of the next sample within the window.
- R3: `avg_valid` is 1 for exactly one clock. That clock follows the edge that accepts the 256th sample of a window. `avg_valid` is 0 at all other times.
- R4: While `avg_valid` is 1, `avg_out[8*i+7:8*i]` holds the number of accepted samples in the just-closed window for which `bits_in[i]` was 1. Counting restarts at zero for the sample accepted next.
- R5: A window in which all 256 accepted samples of a channel are 1 reports 255 for that channel.
- R6: `bits_in` is ignored in any cycle where `sample_en` is 0.
- R7: Channels are independent. The result of one channel does not depend on the bits of any other channel.
- R8: `avg_out` keeps its value from one `avg_valid` pulse until the next.
- R9: In the cycle where `avg_valid` is 1, `dither_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Accepts `bits_in` as one sample on this edge |
| bits_in | input | 8 | One comparator decision per channel |
| dither_code | output | 8 | Ramp code for the dither DAC; equals the sample index in the window |
| avg_out | output | 64 | Eight 8-bit channel results; channel i in bits 8i+7..8i |
| avg_valid | output | 1 | One-clock strobe when a window's results are loaded |

## Verification
Some internal faults show at the ports almost at once:
- A wrong window index shows on `dither_code` at the next sample. It also moves the `avg_valid` pulse away from the 256th sample, so the fault shows within one window.
- A fault in the state machine shows as a missing, doubled or stretched strobe.

Other faults stay hidden longer. A wrong count or a missed counter restart only becomes visible at the next strobe, up to 256 samples later. To expose such faults, the bench mixes windows of known content with random windows:
- windows of all ones, which test saturation;
- windows of all zeros, with ones driven only while `sample_en` is 0, which test that idle bits are ignored;
- windows where each channel uses a different density of ones.

// File: rtl/rda_pkg.sv
package rda_pkg;

    typedef enum logic [1:0] {
        SEQ_PRIME = 2'd0,
        SEQ_ACCUM = 2'd1,
        SEQ_EMIT  = 2'd2
    } seq_state_t;

    // Clamp a count that may equal the full window to the result width.
    function automatic logic [7:0] clamp8(input logic [8:0] value);
        return value[8] ? 8'hFF : value[7:0];
    endfunction

endpackage

// File: rtl/rda_sequencer.sv
module rda_sequencer #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    output logic [RES_BITS-1:0] dither_code,
    output logic                window_close,
    output logic                avg_valid
);
    import rda_pkg::*;

    localparam logic [RES_BITS-1:0] LAST_IDX = {RES_BITS{1'b1}};

    logic [RES_BITS-1:0] idx_q;
    seq_state_t          state_q, state_d;

    // The window index doubles as the dither ramp code.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         idx_q <= '0;
        else if (sample_en) idx_q <= idx_q + 1'b1;
    end

    assign window_close = sample_en && (idx_q == LAST_IDX);
    assign dither_code  = idx_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_PRIME;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_PRIME: if (window_close) state_d = SEQ_EMIT;   // close_first
            SEQ_ACCUM: if (window_close) state_d = SEQ_EMIT;   // close_next
            SEQ_EMIT:  state_d = SEQ_ACCUM;                    // resume
            default:   state_d = SEQ_PRIME;
        endcase
    end

    // Output logic.
    always_comb begin
        avg_valid = 1'b0;
        unique case (state_q)
            SEQ_PRIME: avg_valid = 1'b0;
            SEQ_ACCUM: avg_valid = 1'b0;
            SEQ_EMIT:  avg_valid = 1'b1;
            default:   avg_valid = 1'b0;
        endcase
    end

    assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> dither_code == $past(dither_code) + 1'b1);
    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(dither_code));
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> !avg_valid);
    assert_valid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_valid) |-> $past(sample_en) && ($past(dither_code) == LAST_IDX));
    assert_valid_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> dither_code == '0);

endmodule

// File: rtl/rda_chan_counter.sv
module rda_chan_counter #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                window_close,
    input  logic                bit_in,
    output logic [RES_BITS-1:0] result
);
    localparam int             CNT_W  = RES_BITS + 1;
    localparam logic [CNT_W-1:0] WINDOW = CNT_W'(1) << RES_BITS;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt_q + CNT_W'(bit_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            result <= '0;
        end else if (window_close) begin
            cnt_q  <= '0;
            result <= cnt_next[RES_BITS] ? {RES_BITS{1'b1}} : cnt_next[RES_BITS-1:0];
        end else if (sample_en) begin
            cnt_q  <= cnt_next;
        end
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < WINDOW);
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        window_close |=> cnt_q == '0);
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !window_close |=> $stable(result));
    assert_idle_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(cnt_q));

endmodule

// File: rtl/ramp_dither_avg.sv
module ramp_dither_avg #(
    parameter int CHANNELS = 8,
    parameter int RES_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_en,
    input  logic [CHANNELS-1:0]          bits_in,
    output logic [RES_BITS-1:0]          dither_code,
    output logic [CHANNELS*RES_BITS-1:0] avg_out,
    output logic                         avg_valid
);
    logic window_close;

    rda_sequencer #(.RES_BITS(RES_BITS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .dither_code  (dither_code),
        .window_close (window_close),
        .avg_valid    (avg_valid)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        rda_chan_counter #(.RES_BITS(RES_BITS)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_en    (sample_en),
            .window_close (window_close),
            .bit_in       (bits_in[ch]),
            .result       (avg_out[ch*RES_BITS +: RES_BITS])
        );
    end

    assert_valid_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid && !$past(window_close) |-> $stable(avg_out));

endmodule

// File: tb/sim_ramp_dither_avg.sv
`timescale 1ns/1ps
module sim_ramp_dither_avg;
    localparam int CH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_en = 1'b0;
    logic [CH-1:0] bits_in = '0;
    logic [7:0]    dither_code;
    logic [63:0]   avg_out;
    logic          avg_valid;

    int checks = 0;
    int failures = 0;
    int ones [CH];
    logic [7:0] last_res [CH];
    int unsigned seed_init;

    ramp_dither_avg u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .bits_in(bits_in),
        .dither_code(dither_code), .avg_out(avg_out), .avg_valid(avg_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int n);
        return (n > 255) ? 255 : n;
    endfunction

    // mode 0: random with density per channel; 1: all ones; 2: all zeros, idle ones
    function automatic logic [CH-1:0] pick_bits(input int mode);
        logic [CH-1:0] b;
        if (mode == 1) return '1;
        if (mode == 2) return '0;
        for (int c = 0; c < CH; c++) b[c] = (($urandom % 256) < c * 36);
        return b;
    endfunction

    task automatic run_window(input int mode, input bit check_hold);
        for (int c = 0; c < CH; c++) ones[c] = 0;
        for (int s = 0; s < 256; s++) begin
            int gap;
            logic [CH-1:0] b;
            gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                sample_en = 1'b0;
                bits_in = (mode == 2) ? '1 : CH'($urandom);   // R6: idle bits ignored
            end
            @(negedge clk);
            chk("R2 dither_code", dither_code, s);
            if (check_hold && s == 128)
                for (int c = 0; c < CH; c++)
                    chk("R8 hold", avg_out[c*8 +: 8], last_res[c]);
            b = pick_bits(mode);
            sample_en = 1'b1;
            bits_in = b;
            for (int c = 0; c < CH; c++) ones[c] += b[c];
            @(posedge clk);
            #2;
            sample_en = 1'b0;
            if (s < 255) chk("R3 no early valid", avg_valid, 0);
        end
        chk("R3 valid pulse", avg_valid, 1);
        chk("R9 code wrapped", dither_code, 0);
        for (int c = 0; c < CH; c++) begin
            chk((mode == 1) ? "R5 saturate" : "R4 R7 count", avg_out[c*8 +: 8], clamp(ones[c]));
            last_res[c] = avg_out[c*8 +: 8];
        end
        @(posedge clk);
        #2;
        chk("R3 single pulse", avg_valid, 0);
    endtask

    initial begin
        seed_init = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #2;
        chk("R1 code", dither_code, 0);
        chk("R1 valid", avg_valid, 0);
        chk("R1 out", (avg_out == 64'd0) ? 1 : 0, 1);
        rst_n = 1'b1;
        run_window(0, 1'b0);
        run_window(1, 1'b1);
        run_window(2, 1'b1);
        run_window(0, 1'b1);
        run_window(0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule